// File: doc/BRIEF.md
# Grouped DMA Channel Priority Arbiter

This block decides which DMA channel the transfer engine serves next. The channels are split into equal groups. Each group carries a programmable group priority, and each channel carries a programmable priority that ranks it among the channels of its own group. Each channel has two request lines, a software request and a hardware request, and either one makes the channel pending. When no grant is outstanding, the arbiter picks the group with the highest priority that has any pending channel. Inside that group it picks the channel with the highest priority. It then registers the winner as the grant.

The grant works as a valid/ready style hand-off. `gnt_valid_o` qualifies `gnt_ch_o`. The engine accepts the grant by pulsing `done_i`, and until it does so both grant outputs stay frozen, whatever the requests do. A `done_i` that arrives while no grant is held has no effect.

Each time the arbiter grants, it also checks the priority setup. If two groups share a priority, it sets a group-priority error flag. If the selected group holds two channels with the same priority, it sets a channel-priority error flag. The engine can report a failed transfer, and the arbiter then records the number of the granted channel. All error flags stay set until software writes ones to clear them, and any set flag drives the error interrupt.

Top module: `gdma_group_arbiter`

## Requirements
- R1: After reset, `gnt_valid_o`, `ack_o`, `err_irq_o` and `stat_o` are all zero. Every channel priority resets to the channel's position inside its group (channel number modulo 8), and every group priority resets to the group number.
- R2: Among the groups with at least one pending channel (`sw_req_i | hw_req_i`), the group with the larger group-priority value wins. A lower group is not granted while a higher group still has a pending channel at an arbitration point.
- R3: Inside the winning group, the pending channel with the larger channel-priority value wins.
- R4: When several groups, or several channels, share the winning priority value, the lowest-numbered one is chosen.
- R5: Arbitration takes place only while no grant is held. The grant appears on the clock edge after the request is seen. `gnt_ch_o` stays stable until `done_i` is sampled high, and `gnt_valid_o` falls on that same edge. A `done_i` sampled while no grant is held has no effect.
- R6: `ack_o` is one-hot or zero. Bit c is high only while channel c holds the grant and `hw_req_i[c]` is high; a channel granted through a software request alone gets no acknowledge.
- R7: Status bit 0 (group-priority error) is set at any grant while two groups have equal priority values, whichever group wins.
- R8: Status bit 1 (channel-priority error) is set at a grant only when the selected group contains two channels with equal priority values. Duplicates in a group that was not selected do not set it.
- R9: When `done_i` and `xfer_err_i` are sampled high together while a grant is held, status bit 2 is set and status bits [6:3] load the granted channel number. The channel field is loaded again every time this recurs, and no other event changes it.
- R10: A write to address 31 clears each of status bits 0, 1 and 2 whose matching write-data bit (bits 0, 1, 2) is one. The channel field is left unchanged. A flag that is being set in the same cycle stays set.
- R11: `err_irq_o` is high exactly while at least one of status bits 0 to 2 is set.
- R12: A configuration write to addresses 0 to 15 loads that channel's priority from `cfg_wdata_i[2:0]`. A write to address 16 + g loads group g's priority from `cfg_wdata_i[0]`. Writes to any other address leave every priority unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req_i | input | 16 | Software request, one bit per channel |
| hw_req_i | input | 16 | Hardware request, one bit per channel |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration write address |
| cfg_wdata_i | input | 3 | Configuration write data |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_ch_o | output | 4 | Granted channel number |
| done_i | input | 1 | Engine has finished the granted transfer |
| xfer_err_i | input | 1 | The finishing transfer failed (qualified by `done_i`) |
| ack_o | output | 16 | Per-channel acknowledge to the hardware requester |
| err_irq_o | output | 1 | Error interrupt |
| stat_o | output | 7 | Status: [0] group-priority error, [1] channel-priority error, [2] transfer error, [6:3] error channel |

## Verification
The stickiness and clear assertions assume that software does not clear a flag in the same cycle that an arbitration or a failed transfer could set it. The bench therefore issues every status-clearing write only while no request is pending and no grant is held. The hold assertion assumes that `done_i` is a single-cycle pulse. The bench keeps each `done_i` pulse one cycle long, drives it once on purpose while idle to show that it is ignored, and changes every input only on the falling clock edge.

// File: rtl/gdma_arb_pkg.sv
package gdma_arb_pkg;

  // Default sizing of the arbiter
  localparam int DEF_NUM_GRP    = 2;
  localparam int DEF_CH_PER_GRP = 8;
  localparam int DEF_CPRI_W     = 3;
  localparam int DEF_GPRI_W     = 1;

  // Status field positions
  localparam int ST_GPE = 0;
  localparam int ST_CPE = 1;
  localparam int ST_XE  = 2;
  localparam int ST_CH  = 3;

  // Configuration data width: wide enough for either priority and the clear mask
  function automatic int cfg_dw(input int cw, input int gw);
    int m;
    m = (cw > gw) ? cw : gw;
    return (m > 3) ? m : 3;
  endfunction

endpackage

// File: rtl/gdma_pick.sv
// Highest value wins, lowest index on ties, among the valid entries.
module gdma_pick #(
  parameter int N  = 8,
  parameter int W  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   valid_i,
  input  logic [N*W-1:0] pri_i,
  output logic           found_o,
  output logic [IW-1:0]  idx_o
);

  logic [W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (!found_o || (pri_i[i*W +: W] > best))) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = pri_i[i*W +: W];
      end
    end
  end

endmodule

// File: rtl/gdma_prio_regs.sv
// Priority storage plus uniqueness checks on the stored values.
module gdma_prio_regs #(
  parameter int NUM_GRP    = 2,
  parameter int CH_PER_GRP = 8,
  parameter int CPRI_W     = 3,
  parameter int GPRI_W     = 1,
  parameter int AW         = 5,
  parameter int DW         = 3,
  localparam int NUM_CH    = NUM_GRP * CH_PER_GRP
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NUM_CH*CPRI_W-1:0]   cpri_o,
  output logic [NUM_GRP*GPRI_W-1:0]  gpri_o,
  output logic                       grp_dup_o,
  output logic [NUM_GRP-1:0]         chan_dup_o
);

  logic [CPRI_W-1:0] cpri_q [NUM_CH];
  logic [GPRI_W-1:0] gpri_q [NUM_GRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) cpri_q[c] <= CPRI_W'(c % CH_PER_GRP);
      for (int g = 0; g < NUM_GRP; g++) gpri_q[g] <= GPRI_W'(g);
    end else if (we_i) begin
      for (int c = 0; c < NUM_CH; c++)
        if (addr_i == AW'(c)) cpri_q[c] <= wdata_i[CPRI_W-1:0];
      for (int g = 0; g < NUM_GRP; g++)
        if (addr_i == AW'(NUM_CH + g)) gpri_q[g] <= wdata_i[GPRI_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cflat
    assign cpri_o[c*CPRI_W +: CPRI_W] = cpri_q[c];
  end
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gflat
    assign gpri_o[g*GPRI_W +: GPRI_W] = gpri_q[g];
  end

  // Pairwise equality among groups, and among channels of each group
  always_comb begin
    grp_dup_o  = 1'b0;
    chan_dup_o = '0;
    for (int a = 0; a < NUM_GRP; a++)
      for (int b = a + 1; b < NUM_GRP; b++)
        if (gpri_q[a] == gpri_q[b]) grp_dup_o = 1'b1;
    for (int g = 0; g < NUM_GRP; g++)
      for (int a = 0; a < CH_PER_GRP; a++)
        for (int b = a + 1; b < CH_PER_GRP; b++)
          if (cpri_q[g*CH_PER_GRP + a] == cpri_q[g*CH_PER_GRP + b]) chan_dup_o[g] = 1'b1;
  end

  // R12: priorities move only on a write strobe
  a_r12_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(cpri_o) && $stable(gpri_o)));

endmodule

// File: rtl/gdma_err_status.sv
// Sticky error flags with write-one-to-clear and the recorded channel.
module gdma_err_status #(
  parameter int CH_W = 4,
  localparam int SW  = CH_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_gpe_i,
  input  logic            set_cpe_i,
  input  logic            set_xe_i,
  input  logic [CH_W-1:0] xe_ch_i,
  input  logic [2:0]      clr_i,
  output logic [SW-1:0]   stat_o,
  output logic            err_irq_o
);

  logic            gpe_q, cpe_q, xe_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpe_q <= 1'b0;
      cpe_q <= 1'b0;
      xe_q  <= 1'b0;
      ch_q  <= '0;
    end else begin
      gpe_q <= set_gpe_i | (gpe_q & ~clr_i[0]);
      cpe_q <= set_cpe_i | (cpe_q & ~clr_i[1]);
      xe_q  <= set_xe_i  | (xe_q  & ~clr_i[2]);
      if (set_xe_i) ch_q <= xe_ch_i;
    end
  end

  assign stat_o    = {ch_q, xe_q, cpe_q, gpe_q};
  assign err_irq_o = gpe_q | cpe_q | xe_q;

  // R10: flags persist until cleared
  a_r10_gpe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_q && !clr_i[0] |=> gpe_q);
  a_r10_cpe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[1] && !set_cpe_i |=> !cpe_q);
  // R9: the channel field moves only on a recorded transfer error
  a_r9_channel_only_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    !set_xe_i |=> $stable(ch_q));

endmodule

// File: rtl/gdma_group_arbiter.sv
module gdma_group_arbiter
  import gdma_arb_pkg::*;
#(
  parameter int NUM_GRP    = DEF_NUM_GRP,
  parameter int CH_PER_GRP = DEF_CH_PER_GRP,
  parameter int CPRI_W     = DEF_CPRI_W,
  parameter int GPRI_W     = DEF_GPRI_W,
  localparam int NUM_CH    = NUM_GRP * CH_PER_GRP,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CFG_AW    = $clog2(NUM_CH + NUM_GRP + 1),
  localparam int CFG_DW    = cfg_dw(CPRI_W, GPRI_W),
  localparam int STAT_W    = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sw_req_i,
  input  logic [NUM_CH-1:0] hw_req_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              gnt_valid_o,
  output logic [CH_W-1:0]   gnt_ch_o,
  input  logic              done_i,
  input  logic              xfer_err_i,
  output logic [NUM_CH-1:0] ack_o,
  output logic              err_irq_o,
  output logic [STAT_W-1:0] stat_o
);

  localparam int GIW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int LIW = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1;
  localparam int GSPAN = CH_PER_GRP * CPRI_W;

  logic [NUM_CH*CPRI_W-1:0]  cpri;
  logic [NUM_GRP*GPRI_W-1:0] gpri;
  logic                      grp_dup;
  logic [NUM_GRP-1:0]        chan_dup;

  gdma_prio_regs #(
    .NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP), .CPRI_W(CPRI_W),
    .GPRI_W(GPRI_W), .AW(CFG_AW), .DW(CFG_DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .cpri_o(cpri), .gpri_o(gpri),
    .grp_dup_o(grp_dup), .chan_dup_o(chan_dup)
  );

  // Pending channels and groups
  logic [NUM_CH-1:0]  all_req;
  logic [NUM_GRP-1:0] grp_req;
  assign all_req = sw_req_i | hw_req_i;

  // Level 1: group selection
  logic           grp_found;
  logic [GIW-1:0] grp_idx;

  gdma_pick #(.N(NUM_GRP), .W(GPRI_W)) u_grp_pick (
    .valid_i(grp_req), .pri_i(gpri), .found_o(grp_found), .idx_o(grp_idx)
  );

  // Level 2: one channel picker per group
  logic [NUM_GRP-1:0] ch_found;
  logic [LIW-1:0]     ch_idx [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_req[g] = |all_req[g*CH_PER_GRP +: CH_PER_GRP];
    gdma_pick #(.N(CH_PER_GRP), .W(CPRI_W)) u_ch_pick (
      .valid_i(all_req[g*CH_PER_GRP +: CH_PER_GRP]),
      .pri_i(cpri[g*GSPAN +: GSPAN]),
      .found_o(ch_found[g]),
      .idx_o(ch_idx[g])
    );
  end

  logic [CH_W-1:0] win_ch;
  logic            arb_fire;

  assign win_ch   = CH_W'(grp_idx) * CH_W'(CH_PER_GRP) + CH_W'(ch_idx[grp_idx]);
  assign arb_fire = !gnt_valid_o && grp_found;

  // Grant register: loaded when idle, held until the engine reports done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_o <= 1'b0;
      gnt_ch_o    <= '0;
    end else if (arb_fire) begin
      gnt_valid_o <= 1'b1;
      gnt_ch_o    <= win_ch;
    end else if (gnt_valid_o && done_i) begin
      gnt_valid_o <= 1'b0;
    end
  end

  // Acknowledge only toward a hardware requester that is still asserting
  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      ack_o[c] = gnt_valid_o && (gnt_ch_o == CH_W'(c)) && hw_req_i[c];
  end

  // Error status
  logic [2:0] clr;
  assign clr = (cfg_we_i && (cfg_addr_i == '1)) ? cfg_wdata_i[2:0] : 3'b000;

  gdma_err_status #(.CH_W(CH_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_gpe_i(arb_fire && grp_dup),
    .set_cpe_i(arb_fire && chan_dup[grp_idx]),
    .set_xe_i(gnt_valid_o && done_i && xfer_err_i),
    .xe_ch_i(gnt_ch_o),
    .clr_i(clr),
    .stat_o(stat_o),
    .err_irq_o(err_irq_o)
  );

  // R2: the winner always belongs to a pending group with a pending channel
  a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fire |-> (all_req[win_ch] && ch_found[grp_idx]));
  // R5: grant held steady until done
  a_r5_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o && !done_i |=> gnt_valid_o && $stable(gnt_ch_o));
  a_r5_grant_release: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o && done_i |=> !gnt_valid_o);
  // R6: acknowledge is one-hot and requires a held grant
  a_r6_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  a_r6_ack_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> gnt_valid_o);

endmodule

// File: tb/gdma_group_arbiter_test.sv
module gdma_group_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sw_req = '0;
  logic [15:0] hw_req = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [2:0]  cfg_wdata = '0;
  logic        gnt_valid;
  logic [3:0]  gnt_ch;
  logic        done = 1'b0;
  logic        xfer_err = 1'b0;
  logic [15:0] ack;
  logic        err_irq;
  logic [6:0]  stat;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gdma_group_arbiter uut (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .hw_req_i(hw_req),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .gnt_valid_o(gnt_valid), .gnt_ch_o(gnt_ch), .done_i(done),
    .xfer_err_i(xfer_err), .ack_o(ack), .err_irq_o(err_irq), .stat_o(stat)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [2:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // Drop requests, finish the held transfer and confirm the grant is gone
  task automatic finish_grant(input logic with_err);
    sw_req = '0; hw_req = '0;
    done = 1'b1; xfer_err = with_err;
    tick();
    done = 1'b0; xfer_err = 1'b0;
    chk("R5", "valid after done", 32'(gnt_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "valid", 32'(gnt_valid), 0);
    chk("R1", "ack", 32'(ack), 0);
    chk("R1", "status", 32'(stat), 0);
    chk("R1", "irq", 32'(err_irq), 0);
  endtask

  task automatic t_channel_priority();
    sw_req = 16'h0024;              // channels 2 and 5, default priorities 2 and 5
    tick();
    chk("R3", "valid", 32'(gnt_valid), 1);
    chk("R3", "channel", 32'(gnt_ch), 5);
    chk("R6", "ack without hw request", 32'(ack), 0);
    sw_req = 16'h0080;              // channel 7 appears while 5 is held
    tick();
    chk("R5", "held channel", 32'(gnt_ch), 5);
    done = 1'b1; tick(); done = 1'b0;
    chk("R5", "valid after done", 32'(gnt_valid), 0);
    tick();
    chk("R5", "regrant channel", 32'(gnt_ch), 7);
    chk("R8", "no error on unique setup", 32'(stat), 0);
    finish_grant(1'b0);
  endtask

  task automatic t_group_priority();
    sw_req = 16'h0208;              // channel 3 (group 0) and channel 9 (group 1)
    tick();
    chk("R2", "higher group", 32'(gnt_ch), 9);
    done = 1'b1; tick(); done = 1'b0;
    tick();
    chk("R2", "higher group still pending", 32'(gnt_ch), 9);
    sw_req = 16'h0008;
    done = 1'b1; tick(); done = 1'b0;
    tick();
    chk("R2", "lower group after drain", 32'(gnt_ch), 3);
    finish_grant(1'b0);
    cfg_write(5'd16, 3'd1);
    cfg_write(5'd17, 3'd0);
    sw_req = 16'h0208;
    tick();
    chk("R12", "swapped group priorities", 32'(gnt_ch), 3);
    finish_grant(1'b0);
    cfg_write(5'd16, 3'd0);
    cfg_write(5'd17, 3'd1);
  endtask

  task automatic t_ack();
    hw_req = 16'h0400;              // channel 10 by hardware
    tick();
    chk("R6", "granted channel", 32'(gnt_ch), 10);
    chk("R6", "ack bit", 32'(ack), 32'h0400);
    hw_req = '0;
    tick();
    chk("R6", "ack drops with hw request", 32'(ack), 0);
    chk("R5", "grant kept without request", 32'(gnt_valid), 1);
    finish_grant(1'b0);
  endtask

  task automatic t_group_error();
    cfg_write(5'd17, 3'd0);         // both groups priority 0
    sw_req = 16'h0200;              // only group 1 pending
    tick();
    chk("R7", "channel", 32'(gnt_ch), 9);
    chk("R7", "gpe flag", 32'(stat), 1);
    chk("R11", "irq with gpe", 32'(err_irq), 1);
    finish_grant(1'b0);
    sw_req = 16'h0208;
    tick();
    chk("R4", "group tie lowest", 32'(gnt_ch), 3);
    finish_grant(1'b0);
    cfg_write(5'd31, 3'b001);
    chk("R10", "gpe cleared", 32'(stat), 0);
    chk("R11", "irq clear", 32'(err_irq), 0);
    cfg_write(5'd17, 3'd1);
  endtask

  task automatic t_channel_error();
    cfg_write(5'd4, 3'd6);          // channel 4 now equals channel 6
    sw_req = 16'h1000;              // channel 12, group 1 only
    tick();
    chk("R8", "channel", 32'(gnt_ch), 12);
    chk("R8", "no cpe for other group", 32'(stat), 0);
    finish_grant(1'b0);
    sw_req = 16'h0050;              // channels 4 and 6
    tick();
    chk("R4", "channel tie lowest", 32'(gnt_ch), 4);
    chk("R8", "cpe flag", 32'(stat), 2);
    finish_grant(1'b0);
    cfg_write(5'd31, 3'b010);
    chk("R10", "cpe cleared", 32'(stat), 0);
    cfg_write(5'd4, 3'd4);
  endtask

  task automatic t_transfer_error();
    done = 1'b1; xfer_err = 1'b1;   // idle done is ignored
    tick();
    done = 1'b0; xfer_err = 1'b0;
    chk("R9", "idle done ignored", 32'(stat), 0);
    chk("R5", "idle done no grant", 32'(gnt_valid), 0);
    sw_req = 16'h2000;              // channel 13
    tick();
    finish_grant(1'b1);
    chk("R9", "first record", 32'(stat), (13 << 3) | 4);
    chk("R11", "irq on xe", 32'(err_irq), 1);
    sw_req = 16'h0040;              // channel 6
    tick();
    finish_grant(1'b1);
    chk("R9", "recorded again", 32'(stat), (6 << 3) | 4);
    cfg_write(5'd31, 3'b100);
    chk("R10", "xe cleared channel kept", 32'(stat), 6 << 3);
    chk("R11", "irq off", 32'(err_irq), 0);
  endtask

  task automatic t_unused_address();
    cfg_write(5'd20, 3'd7);
    sw_req = 16'h0003;              // channels 0 and 1
    tick();
    chk("R12", "unused address ignored", 32'(gnt_ch), 1);
    chk("R12", "no error flags", 32'(stat[2:0]), 0);
    finish_grant(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_channel_priority();
    t_group_priority();
    t_ack();
    t_group_error();
    t_channel_error();
    t_transfer_error();
    t_unused_address();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule